// File: doc/BRIEF.md
# Four-Lane Interleaved Sine Tone Generator

This block produces a digital sine tone for a converter that samples four times faster than the logic feeding it. On every fabric clock it delivers four consecutive 16-bit signed samples, and each one comes from its own 32-bit phase accumulator. All four accumulators advance by four times the tuning word. After a load, each one starts a single tuning word ahead of the lane before it, so the four lanes together trace one continuous phase ramp at the converter rate.

A start-phase word sets the initial offset. Each lane applies it as a multiple of its lane number plus one. The top bits of each accumulator index a 1024-entry sine table that is computed when the design is elaborated. The tuning and phase inputs act only on a load strobe, which restarts all lanes on the same edge. An enable freezes or advances the whole pipeline. A valid flag marks which output words came from enabled cycles.

Top module: `quad_lane_nco`

## Requirements
- R1: While `rst` is high and on the first edge after it, `samples` is all zero and `valid` is 0.
- R2: On an edge where `load` is 1, lane k (k = 0..3) is set to (k·F + (k+1)·P) mod 2^32, where F is `freq_word` and P is `phase_word`. This takes priority over `en` and happens even when `en` is 0.
- R3: On an edge where `en` is 1 and `load` is 0, every lane adds 4·F_L modulo 2^32 and wraps without saturating. F_L is the `freq_word` captured at the most recent load (0 after reset).
- R4: A lane's sample is round-half-away-from-zero of 32767·sin(2π·a/1024), where a is bits [31:22] of that lane's phase. Lane k is placed on `samples[16k+15:16k]`.
- R5: A phase value present while `en` is 1 at an edge appears on `samples` two edges later, and `valid` equals `en` as sampled two edges earlier.
- R6: While `en` is 0 the accumulators hold their value. Once the two pipeline stages have drained, `samples` holds its last value.
- R7: Changing `freq_word` or `phase_word` without a load does not change the output stream.
- R8: A load that arrives while `en` is 1 restarts the lanes at once. The samples already in the two pipeline stages still come out.
- R9: With P = 0, a load with `en` low, and then `en` held high, the n-th sample in stream order (output word j, lane k, n = 4j+k) equals the table value at bits [31:22] of n·F.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fabric clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Advances accumulators and pipeline |
| load | input | 1 | Restarts all lanes from the tuning and phase words |
| freq_word | input | 32 | Tuning word F (phase step per converter sample) |
| phase_word | input | 32 | Start phase P, 0x8000_0000 = 180 degrees |
| samples | output | 64 | Four signed samples, lane 0 in the low bits |
| valid | output | 1 | Output word came from enabled cycles |

## Verification
The bench builds the block with its default parameters: four lanes, a 32-bit phase, 16-bit samples and a 1024-entry table. With these values the table index and its sign symmetry can be checked against a floating-point reference. A sweep of tuning words walks the top phase bits through every table region and pushes the accumulators across the 2^32 wrap many times. Loads are placed with the enable low, with the enable high and in the middle of a run, and the tuning inputs are changed without a load, so the priority, hold and ignore rules are each reached.

// File: rtl/quad_lane_nco.sv
module quad_lane_nco #(
  parameter int PHASE_W  = 32,
  parameter int LANES    = 4,
  parameter int SAMPLE_W = 16,
  parameter int TABLE_AW = 10
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      en,
  input  logic                      load,
  input  logic [PHASE_W-1:0]        freq_word,
  input  logic [PHASE_W-1:0]        phase_word,
  output logic [LANES*SAMPLE_W-1:0] samples,
  output logic                      valid
);
  localparam int  TABLE_N = 1 << TABLE_AW;
  localparam real AMP     = real'((1 << (SAMPLE_W - 1)) - 1);
  localparam real TWO_PI  = 6.283185307179586;

  function automatic logic [SAMPLE_W-1:0] sine_entry(input int idx);
    real v;
    v = AMP * $sin(TWO_PI * real'(idx) / real'(TABLE_N));
    v = (v < 0.0) ? v - 0.5 : v + 0.5;
    return SAMPLE_W'($rtoi(v));
  endfunction

  logic [SAMPLE_W-1:0] sine_rom [TABLE_N];
  logic [PHASE_W-1:0]  step_q;
  logic [PHASE_W-1:0]  acc      [LANES];
  logic [SAMPLE_W-1:0] look_q   [LANES];
  logic [SAMPLE_W-1:0] out_q    [LANES];
  logic [1:0]          en_pipe;

  for (genvar i = 0; i < TABLE_N; i++) begin : g_rom
    assign sine_rom[i] = sine_entry(i);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      step_q  <= '0;
      en_pipe <= '0;
    end else begin
      en_pipe <= {en_pipe[0], en};
      if (load) step_q <= PHASE_W'(LANES) * freq_word;
    end
  end

  assign valid = en_pipe[1];

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    logic [PHASE_W-1:0] init;
    assign init = PHASE_W'(k) * freq_word + PHASE_W'(k + 1) * phase_word;

    always_ff @(posedge clk) begin
      if (rst) begin
        acc[k]    <= '0;
        look_q[k] <= '0;
        out_q[k]  <= '0;
      end else begin
        if (load)    acc[k]    <= init;
        else if (en) acc[k]    <= acc[k] + step_q;
        if (en)      look_q[k] <= sine_rom[acc[k][PHASE_W-1 -: TABLE_AW]];
        if (en_pipe[0]) out_q[k] <= look_q[k];
      end
    end

    assign samples[k*SAMPLE_W +: SAMPLE_W] = out_q[k];
  end
endmodule

// File: rtl/quad_lane_nco_chk.sv
module quad_lane_nco_chk #(
  parameter int PHASE_W  = 32,
  parameter int LANES    = 4,
  parameter int SAMPLE_W = 16,
  parameter int TABLE_AW = 10
) (
  input logic                      clk,
  input logic                      rst,
  input logic                      en,
  input logic                      load,
  input logic [PHASE_W-1:0]        freq_word,
  input logic [PHASE_W-1:0]        phase_word,
  input logic [LANES*SAMPLE_W-1:0] samples,
  input logic                      valid,
  input logic [PHASE_W-1:0]        acc [LANES]
);
  logic [1:0]         age;
  logic [PHASE_W-1:0] last_f;

  always_ff @(posedge clk) begin
    if (rst) begin
      age    <= '0;
      last_f <= '0;
    end else begin
      if (age != 2'd3) age <= age + 2'd1;
      if (load) last_f <= freq_word;
    end
  end

  AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (rst)
    (age == 2'd3) |-> (valid == $past(en, 2)));  // R5

  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (rst)
    (age == 2'd3 && !$past(en, 2)) |-> $stable(samples));  // R6

  for (genvar k = 0; k < LANES; k++) begin : g_chk
    AST_LOAD_INIT: assert property (@(posedge clk) disable iff (rst)
      (age == 2'd3 && $past(load)) |->
      (acc[k] == PHASE_W'(k) * $past(freq_word) + PHASE_W'(k + 1) * $past(phase_word)));  // R2

    AST_STEP_WRAP: assert property (@(posedge clk) disable iff (rst)
      (age == 2'd3 && $past(en) && !$past(load)) |->
      (acc[k] == $past(acc[k]) + PHASE_W'(LANES) * $past(last_f)));  // R3

    AST_ACC_HOLD: assert property (@(posedge clk) disable iff (rst)
      (age == 2'd3 && !$past(en) && !$past(load)) |-> (acc[k] == $past(acc[k])));  // R6
  end
endmodule

bind quad_lane_nco quad_lane_nco_chk #(
  .PHASE_W(PHASE_W), .LANES(LANES), .SAMPLE_W(SAMPLE_W), .TABLE_AW(TABLE_AW)
) u_chk (.*);

// File: tb/quad_lane_nco_tb.sv
module quad_lane_nco_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        en = 1'b0;
  logic        load = 1'b0;
  logic [31:0] freq_word = '0;
  logic [31:0] phase_word = '0;
  logic [63:0] samples;
  logic        valid;

  int vectors = 0;
  int fails = 0;
  bit done = 1'b0;

  logic [31:0] m_acc [4];
  logic [15:0] m_s1 [4];
  logic [15:0] m_out [4];
  logic [31:0] m_step;
  logic        m_q1, m_q2;

  always #4 clk = ~clk;

  quad_lane_nco u_dut (
    .clk(clk), .rst(rst), .en(en), .load(load),
    .freq_word(freq_word), .phase_word(phase_word),
    .samples(samples), .valid(valid)
  );

  function automatic logic [15:0] ref_sine(input logic [31:0] ph);
    real v;
    int  r;
    v = 32767.0 * $sin(6.283185307179586 * real'(int'(ph[31:22])) / 1024.0);
    if (v >= 0.0) r = int'($floor(v + 0.5));
    else          r = -int'($floor(-v + 0.5));
    return 16'(r);
  endfunction

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    vectors++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h at %0t", tag, got, exp, $time);
    end
  endtask

  task automatic tick(input string tag);
    logic [15:0] s1_old [4];
    @(posedge clk);
    s1_old = m_s1;
    if (rst) begin
      for (int k = 0; k < 4; k++) begin
        m_acc[k] = '0; m_s1[k] = '0; m_out[k] = '0;
      end
      m_step = '0; m_q1 = 1'b0; m_q2 = 1'b0;
    end else begin
      for (int k = 0; k < 4; k++) begin
        if (m_q1) m_out[k] = s1_old[k];
        if (en) m_s1[k] = ref_sine(m_acc[k]);
        if (load) m_acc[k] = 32'(k) * freq_word + 32'(k + 1) * phase_word;
        else if (en) m_acc[k] = m_acc[k] + m_step;
      end
      m_q2 = m_q1;
      m_q1 = en;
      if (load) m_step = 32'd4 * freq_word;
    end
    #2;
    for (int k = 0; k < 4; k++)
      check(tag, 32'(samples[16*k +: 16]), 32'(m_out[k]));
    check(tag, 32'(valid), 32'(m_q2));
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    logic [63:0] hold_val;
    logic [31:0] sweep_f [8];
    sweep_f = '{32'h0040_0000, 32'h0123_4567, 32'h1000_0000, 32'h3FF0_0001,
                32'h7FFF_FFFF, 32'h8000_0000, 32'hC000_0003, 32'hFFFF_FFFF};

    // R1: reset state
    for (int i = 0; i < 3; i++) tick("R1");
    #1 rst = 1'b0;
    tick("R1");
    check("R1", 32'(samples), 32'd0);
    check("R1", 32'(valid), 32'd0);

    // R2: load with enable low, direct lane start values
    #1; freq_word = 32'h0123_4567; phase_word = 32'h2000_0000; load = 1'b1;
    tick("R2");
    #1; load = 1'b0; en = 1'b1;
    tick("R2");
    tick("R2");
    for (int k = 0; k < 4; k++)
      check("R2", 32'(samples[16*k +: 16]),
            32'(ref_sine(32'(k) * 32'h0123_4567 + 32'(k + 1) * 32'h2000_0000)));
    check("R5", 32'(valid), 32'd1);
    for (int i = 0; i < 20; i++) tick("R4");

    // R9: continuous stream with zero phase
    #1; en = 1'b0; load = 1'b1; phase_word = '0; freq_word = 32'h0531_0A07;
    tick("R9");
    #1; load = 1'b0; en = 1'b1;
    tick("R9");
    for (int j = 0; j < 30; j++) begin
      tick("R9");
      for (int k = 0; k < 4; k++)
        check("R9", 32'(samples[16*k +: 16]),
              32'(ref_sine(32'(4 * j + k) * 32'h0531_0A07)));
    end

    // R3: sweep of tuning words across the wrap
    for (int s = 0; s < 8; s++) begin
      #1; load = 1'b1; freq_word = sweep_f[s]; phase_word = 32'(s) * 32'h1357_9BDF;
      tick("R3");
      #1; load = 1'b0;
      for (int i = 0; i < 40; i++) tick("R3");
    end

    // R6: enable low holds outputs after drain
    #1; en = 1'b0;
    tick("R6");
    tick("R6");
    hold_val = samples;
    for (int i = 0; i < 6; i++) begin
      tick("R6");
      check("R6", 32'(samples != hold_val), 32'd0);
    end
    #1; en = 1'b1;
    for (int i = 0; i < 6; i++) tick("R6");

    // R7: inputs change without load
    #1; freq_word = 32'hDEAD_BEEF; phase_word = 32'h8000_0000;
    for (int i = 0; i < 20; i++) tick("R7");

    // R8: load while running, then gaps in enable
    #1; load = 1'b1; freq_word = 32'h0200_0000; phase_word = 32'h8000_0000;
    tick("R8");
    #1; load = 1'b0;
    for (int i = 0; i < 10; i++) tick("R8");
    for (int i = 0; i < 40; i++) begin
      #1; en = (i % 3) != 0; load = (i % 13) == 5;
      freq_word = 32'h0100_0000 + 32'(i) * 32'h0011_0003;
      tick("R8");
    end
    #1; en = 1'b0; load = 1'b0;
    for (int i = 0; i < 4; i++) tick("R5");

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule